// File: doc/BRIEF.md
# Shared-Term Carry-Select Adder

This block adds two unsigned operands and a carry input in a single combinational step. The result is the full sum and a carry output. The operand width is cut into equal blocks. Inside each block, two speculative carry chains run at the same time: one assumes the incoming carry is 0 and the other assumes it is 1. When the real carry into the block resolves, a per-block selector picks one chain's sum bits and carry. The carry that goes on to the next block therefore costs one selector delay per block.

Both speculative chains read one shared set of per-bit terms: generate (a AND b), propagate (a XOR b) and either (a OR b). The block does not build two complete ripple adders. At the lowest bit of a block the two sum candidates are the propagate term and its inverse. The two carry candidates are the generate term and the either term. Higher bits in a chain use the usual generate/propagate recurrence on the same shared terms.

The operand width must be a whole multiple of the block size. A mismatch stops elaboration. There is no register inside the block. Users place it between their own pipeline stages.

Top module: `shcs_adder`

## Requirements
- R1: For every operand pair and carry input, {carry_o, sum_o} equals a_i + b_i + carry_i computed at WIDTH+1 bits.
- R2: With both operands zero, sum_o equals carry_i zero-extended and carry_o is 0.
- R3: With both operands all ones, sum_o is all ones except bit 0, which equals carry_i, and carry_o is 1.
- R4: With a_i all ones and b_i zero, a carry_i of 1 ripples through every block: sum_o becomes zero and carry_o becomes 1. With carry_i 0, sum_o stays all ones and carry_o is 0.
- R5: Alternating operands (a_i with odd bits set, b_i with even bits set) give sum_o all ones and carry_o 0 when carry_i is 0. They give sum_o zero and carry_o 1 when carry_i is 1.
- R6: When both operands have only the top bit set, sum_o is zero and carry_o equals 1.
- R7: A carry generated at the top bit of block k enters bit 0 of block k+1. If both operands are 1 shifted left by k*BLK_W+BLK_W-1, sum_o is 1 shifted left by (k+1)*BLK_W and carry_o is 0. Inside each block, the carry-1 candidate is never 0 while the carry-0 candidate is 1.
- R8: Raising carry_i from 0 to 1 with the same operands increases {carry_o, sum_o} by exactly one. At each block's lowest bit, the carry-1 sum candidate is the inverse of the carry-0 candidate.
- R9: With WIDTH=8 and BLK_W=2, R1 holds for all operand pairs and both carry inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First addend |
| b_i | input | WIDTH | Second addend |
| carry_i | input | 1 | Carry into the lowest block |
| sum_o | output | WIDTH | Sum bits |
| carry_o | output | 1 | Carry out of the top block |

## Verification
The bench builds two copies of the adder. The first uses the default 32-bit width with 4-bit blocks, which is eight blocks. It is driven by directed patterns that aim at each block boundary, plus a few thousand seeded random vectors. The second copy uses an 8-bit width with 2-bit blocks. This narrow copy can be swept over every operand pair and both carry inputs. Every carry path between blocks, and every pairing of candidate selections, is therefore exercised exhaustively at that width.

// File: rtl/shcs_pkg.sv
// Package: shared helpers for the shared-term carry-select adder.
// Assumes widths are positive; callers check divisibility themselves.
package shcs_pkg;

    // Number of blocks for a width and a block size, rounded up.
    function automatic int unsigned block_count(input int unsigned width,
                                                input int unsigned blk_w);
        return (width + blk_w - 1) / blk_w;
    endfunction

    // Lowest bit index of block k.
    function automatic int unsigned block_base(input int unsigned k,
                                               input int unsigned blk_w);
        return k * blk_w;
    endfunction

endpackage

// File: rtl/shcs_terms.sv
// Module: shcs_terms
// Forms the per-bit generate, propagate and either terms that both
// speculative chains of every block read. Purely combinational.
module shcs_terms #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] gen_o,
    output logic [WIDTH-1:0] prop_o,
    output logic [WIDTH-1:0] either_o
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // One gate of each kind per bit position, shared downstream.
        assign gen_o[i]    = a_i[i] & b_i[i];
        assign prop_o[i]   = a_i[i] ^ b_i[i];
        assign either_o[i] = a_i[i] | b_i[i];
    end

endmodule

// File: rtl/shcs_chain.sv
// Module: shcs_chain
// One speculative carry chain of a block under a fixed carry-in
// assumption (ASSUME). Uses only shared terms: the lowest bit reduces to
// prop / ~prop for the sum and gen / either for the carry.
module shcs_chain #(
    parameter int unsigned BLK_W  = 4,
    parameter bit          ASSUME = 1'b0
) (
    input  logic [BLK_W-1:0] gen_i,
    input  logic [BLK_W-1:0] prop_i,
    input  logic [BLK_W-1:0] either_i,
    output logic [BLK_W-1:0] sum_o,
    output logic             carry_o
);

    logic [BLK_W:0] c;

    // Lowest bit: carry-in is the constant assumption.
    if (ASSUME) begin : g_low_one
        assign sum_o[0] = ~prop_i[0];
        assign c[1]     = either_i[0];
    end else begin : g_low_zero
        assign sum_o[0] = prop_i[0];
        assign c[1]     = gen_i[0];
    end
    assign c[0] = ASSUME;

    // Upper bits: generate/propagate ripple on the shared terms.
    for (genvar i = 1; i < BLK_W; i++) begin : g_up
        assign sum_o[i] = prop_i[i] ^ c[i];
        assign c[i+1]   = gen_i[i] | (prop_i[i] & c[i]);
    end

    assign carry_o = c[BLK_W];

    // Unused bit kept only for uniform indexing.
    logic unused_c0;
    assign unused_c0 = c[0];

endmodule

// File: rtl/shcs_block.sv
// Module: shcs_block
// One carry-select block: two speculative chains on shared terms and a
// selector driven by the real carry into the block. Exposes candidates
// so a bound checker can observe them.
module shcs_block #(
    parameter int unsigned BLK_W = 4
) (
    input  logic [BLK_W-1:0] gen_i,
    input  logic [BLK_W-1:0] prop_i,
    input  logic [BLK_W-1:0] either_i,
    input  logic             sel_i,
    output logic [BLK_W-1:0] sum_o,
    output logic             carry_o,
    output logic [BLK_W-1:0] s0_o,
    output logic [BLK_W-1:0] s1_o,
    output logic             c0_o,
    output logic             c1_o
);

    shcs_chain #(.BLK_W(BLK_W), .ASSUME(1'b0)) u_chain0 (
        .gen_i   (gen_i),
        .prop_i  (prop_i),
        .either_i(either_i),
        .sum_o   (s0_o),
        .carry_o (c0_o)
    );

    shcs_chain #(.BLK_W(BLK_W), .ASSUME(1'b1)) u_chain1 (
        .gen_i   (gen_i),
        .prop_i  (prop_i),
        .either_i(either_i),
        .sum_o   (s1_o),
        .carry_o (c1_o)
    );

    // Select the candidate matching the resolved block carry-in.
    always_comb begin
        if (sel_i) begin
            sum_o   = s1_o;
            carry_o = c1_o;
        end else begin
            sum_o   = s0_o;
            carry_o = c0_o;
        end
    end

endmodule

// File: rtl/shcs_adder.sv
// Module: shcs_adder (top)
// Combinational carry-select adder built from equal blocks whose two
// speculative chains share one set of per-bit terms. Assumes WIDTH is a
// multiple of BLK_W; elaboration stops otherwise. No clock, no state.
module shcs_adder
    import shcs_pkg::*;
#(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned BLK_W = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             carry_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_o
);

    localparam int unsigned NBLK = block_count(WIDTH, BLK_W);

    if ((WIDTH % BLK_W) != 0) begin : g_bad_width
        $error("shcs_adder: WIDTH must be a multiple of BLK_W");
    end

    logic [WIDTH-1:0] gen, prop, either;
    logic [NBLK:0]    blk_cin;
    logic [NBLK-1:0]  cand_c0, cand_c1;
    logic [NBLK-1:0]  low_s0, low_s1;

    shcs_terms #(.WIDTH(WIDTH)) u_terms (
        .a_i     (a_i),
        .b_i     (b_i),
        .gen_o   (gen),
        .prop_o  (prop),
        .either_o(either)
    );

    assign blk_cin[0] = carry_i;

    for (genvar k = 0; k < NBLK; k++) begin : g_blk
        localparam int unsigned LO = block_base(k, BLK_W);
        logic [BLK_W-1:0] s0, s1;

        shcs_block #(.BLK_W(BLK_W)) u_block (
            .gen_i   (gen[LO +: BLK_W]),
            .prop_i  (prop[LO +: BLK_W]),
            .either_i(either[LO +: BLK_W]),
            .sel_i   (blk_cin[k]),
            .sum_o   (sum_o[LO +: BLK_W]),
            .carry_o (blk_cin[k+1]),
            .s0_o    (s0),
            .s1_o    (s1),
            .c0_o    (cand_c0[k]),
            .c1_o    (cand_c1[k])
        );

        // Lowest-bit candidates brought out for the checker.
        assign low_s0[k] = s0[0];
        assign low_s1[k] = s1[0];
    end

    assign carry_o = blk_cin[NBLK];

endmodule

// File: rtl/shcs_adder_chk.sv
// Module: shcs_adder_chk
// Assertion checker bound to shcs_adder. The adder is combinational, so
// the checks are immediate assertions evaluated whenever inputs settle.
module shcs_adder_chk #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned BLK_W = 4,
    parameter int unsigned NBLK  = 8
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic             carry_i,
    input logic [WIDTH-1:0] sum_o,
    input logic             carry_o,
    input logic [NBLK:0]    blk_cin,
    input logic [NBLK-1:0]  cand_c0,
    input logic [NBLK-1:0]  cand_c1,
    input logic [NBLK-1:0]  low_s0,
    input logic [NBLK-1:0]  low_s1
);

    logic [WIDTH:0] ref_sum;
    logic           known;

    // Reference total and a guard against unknown inputs.
    always_comb begin
        ref_sum = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, carry_i};
        known   = !$isunknown({a_i, b_i, carry_i});
    end

    // Whole-result and per-block checks.
    always_comb begin
        if (known) begin
            // R1
            total_sum_chk: assert ({carry_o, sum_o} == ref_sum);
            // R2
            zero_operands_chk: assert (!(a_i == '0 && b_i == '0) ||
                                       (sum_o == {{(WIDTH-1){1'b0}}, carry_i} && !carry_o));
            // R7
            cand_order_chk: assert ((~cand_c0 | cand_c1) == '1);
            // R8
            low_pair_chk: assert (low_s1 == ~low_s0);
            // R7
            first_sel_chk: assert (blk_cin[0] == carry_i);
        end
    end

    // Carry entering each upper block matches the partial-width sum.
    for (genvar k = 1; k < NBLK; k++) begin : g_bnd
        localparam int unsigned LO = k * BLK_W;
        logic [LO:0] part;
        always_comb begin
            part = {1'b0, a_i[LO-1:0]} + {1'b0, b_i[LO-1:0]} + {{LO{1'b0}}, carry_i};
            if (known) begin
                // R7
                boundary_carry_chk: assert (blk_cin[k] == part[LO]);
            end
        end
    end

endmodule

bind shcs_adder shcs_adder_chk #(
    .WIDTH(WIDTH),
    .BLK_W(BLK_W),
    .NBLK (NBLK)
) u_shcs_adder_chk (
    .a_i    (a_i),
    .b_i    (b_i),
    .carry_i(carry_i),
    .sum_o  (sum_o),
    .carry_o(carry_o),
    .blk_cin(blk_cin),
    .cand_c0(cand_c0),
    .cand_c1(cand_c1),
    .low_s0 (low_s0),
    .low_s1 (low_s1)
);

// File: tb/shcs_adder_bench.sv
`timescale 1ns/1ps
// Bench for shcs_adder: directed corners and seeded random vectors on a
// 32-bit/4-bit build, plus an exhaustive sweep of an 8-bit/2-bit build.
module shcs_adder_bench;

    localparam int unsigned W  = 32;
    localparam int unsigned BW = 4;
    localparam int unsigned NW = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int cycles = 0;

    logic [W-1:0]  a, b, s;
    logic          ci, co;
    logic [NW-1:0] na, nb, ns;
    logic          nci, nco;

    shcs_adder #(.WIDTH(W), .BLK_W(BW)) u_shcs_adder (
        .a_i(a), .b_i(b), .carry_i(ci), .sum_o(s), .carry_o(co)
    );

    shcs_adder #(.WIDTH(NW), .BLK_W(2)) u_shcs_adder_w8 (
        .a_i(na), .b_i(nb), .carry_i(nci), .sum_o(ns), .carry_o(nco)
    );

    // Expected 33-bit result from the requirement, independent of the RTL.
    function automatic logic [W:0] exp_add(input logic [W-1:0] x,
                                           input logic [W-1:0] y,
                                           input logic c);
        logic [W:0] r;
        r = {1'b0, x};
        r = r + {1'b0, y};
        r = r + {{W{1'b0}}, c};
        return r;
    endfunction

    task automatic check(input string tag, input logic [W:0] got,
                         input logic [W:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Drive the wide copy, let it settle, compare.
    task automatic apply(input string tag, input logic [W-1:0] x,
                         input logic [W-1:0] y, input logic c,
                         input logic [W:0] exp);
        a = x; b = y; ci = c;
        #2;
        check(tag, {co, s}, exp);
    endtask

    // Cycle watchdog.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog got=%0d exp<190000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [W:0]    r0, r1;
        logic [NW:0]   nexp;
        a = '0; b = '0; ci = 1'b0;
        na = '0; nb = '0; nci = 1'b0;
        #3;
        // R2: rest state with zero inputs
        check("R2 zero cin0", {co, s}, '0);
        apply("R2 zero cin1", '0, '0, 1'b1, 33'h0_0000_0001);
        // R3: all ones
        apply("R3 ones cin0", '1, '1, 1'b0, 33'h1_FFFF_FFFE);
        apply("R3 ones cin1", '1, '1, 1'b1, 33'h1_FFFF_FFFF);
        // R4: carry through every block
        apply("R4 prop cin1", '1, '0, 1'b1, 33'h1_0000_0000);
        apply("R4 prop cin0", '1, '0, 1'b0, 33'h0_FFFF_FFFF);
        apply("R4 prop swap", '0, '1, 1'b1, 33'h1_0000_0000);
        // R5: alternating bits
        apply("R5 alt cin0", 32'hAAAA_AAAA, 32'h5555_5555, 1'b0, 33'h0_FFFF_FFFF);
        apply("R5 alt cin1", 32'hAAAA_AAAA, 32'h5555_5555, 1'b1, 33'h1_0000_0000);
        // R6: only the top bit
        apply("R6 top bit", 32'h8000_0000, 32'h8000_0000, 1'b0, 33'h1_0000_0000);
        // R7: carry from top bit of block k lands in block k+1
        for (int k = 0; k < 7; k++) begin
            apply("R7 boundary", 32'd1 << (k*BW + BW - 1), 32'd1 << (k*BW + BW - 1),
                  1'b0, 33'd1 << ((k+1)*BW));
        end
        // R1 and R8: seeded random vectors
        void'($urandom(32'h5EED_1234));
        for (int n = 0; n < 3000; n++) begin
            logic [W-1:0] x, y;
            x = $urandom();
            y = $urandom();
            if (n % 5 == 0) y = ~x;
            apply("R1 random", x, y, 1'(n), exp_add(x, y, 1'(n)));
            a = x; b = y; ci = 1'b0; #2; r0 = {co, s};
            ci = 1'b1; #2; r1 = {co, s};
            check("R8 cin step", r1, r0 + 33'd1);
        end
        // R9: exhaustive narrow build
        for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y++) begin
                for (int c = 0; c < 2; c++) begin
                    na = 8'(x); nb = 8'(y); nci = 1'(c);
                    #1;
                    nexp = 9'(x + y + c);
                    checks++;
                    if ({nco, ns} !== nexp) begin
                        fails++;
                        $display("FAIL R9 got=%h exp=%h", {nco, ns}, nexp);
                    end
                end
            end
        end
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule